// File: doc/BRIEF.md
# Periodic Split Transaction Pipeline

This block carries the scheduled (interrupt and isochronous) traffic of a speed-translating hub from the fast upstream link to the slow downstream bus and back. A start-split request from upstream deposits a descriptor (endpoint tag plus payload) into an in-order start queue. A downstream handler takes descriptors from that queue one at a time, presents each on the slow-bus issue handshake, waits for the slow bus to report an outcome, and files the outcome with its tag into a separate in-order result queue. A later complete-split request from upstream collects the oldest result. The queues of this path are its own and are not shared with bulk or control traffic.

Results are matched by tag. A complete-split whose tag matches the oldest result gets that result. A mismatched tag gets an error, and the stale result is thrown away. With no result waiting, the answer is "pending". A frame counter advances on each frame tick. Every queued entry carries the frame in which it was written. An entry that has lived through three ticks has missed its budget and is purged from the head of its queue. While anything is queued or in flight, a pending output tells the non-periodic side to hold off. A start-split that finds the start queue full is dropped, and a sticky overflow flag is raised.

The downstream handler is a three-state machine. IDLE leaves to ISSUE when it takes a live descriptor. It stays in IDLE when it discards an expired one. ISSUE leaves to POST when the done strobe arrives. POST returns to IDLE once the result is written to a queue with space.

Top module: `psplit_pipe`

## Requirements
- R1: After reset, `periodic_pending`, `ds_issue_valid`, `ss_overflow` and `cs_rsp_valid` are all 0.
- R2: Start-splits are issued downstream in the order they were accepted. A descriptor accepted at clock edge k into an empty queue, with the handler idle, appears on `ds_issue_valid`/`ds_issue_tag`/`ds_issue_data` after edge k+1. The issue is held unchanged until the edge at which `ds_done` is sampled high.
- R3: After the edge at which `ds_done` is sampled, the result is filed two edges later. A complete-split sampled on that second edge sees it.
- R4: A complete-split whose tag equals the oldest result's tag is answered after the next edge with `cs_rsp_valid`=1, `cs_rsp_kind`=2'b10 (done) and `cs_rsp_data` equal to the result. That result is then removed.
- R5: A complete-split whose tag differs from the oldest result's tag is answered with `cs_rsp_kind`=2'b11 (error) and `cs_rsp_data`=0. The stale result is removed.
- R6: A complete-split while no result is queued is answered with `cs_rsp_kind`=2'b01 (pending) and `cs_rsp_data`=0.
- R7: `periodic_pending` is 1 exactly while the start queue holds an entry, the handler is not IDLE, or the result queue holds an entry.
- R8: A start-split presented while the start queue is full is discarded and never issued. `ss_overflow` then goes to 1 and stays there until reset.
- R9: An entry whose age reaches three frame ticks is purged. For a start queue entry this happens when it reaches the head and before it is issued. For a result queue entry it happens at the head, in a cycle without a complete-split. An entry aged two ticks is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_valid | input | 1 | Start-split request strobe |
| ss_tag | input | TAG_W | Endpoint tag of the start-split |
| ss_data | input | DATA_W | Descriptor payload |
| cs_req | input | 1 | Complete-split request strobe |
| cs_tag | input | TAG_W | Endpoint tag of the complete-split |
| cs_rsp_valid | output | 1 | Response strobe, one cycle after `cs_req` |
| cs_rsp_kind | output | 2 | 01 pending, 10 done, 11 error |
| cs_rsp_data | output | RES_W | Result for a done response, else 0 |
| ds_issue_valid | output | 1 | A transaction is presented to the slow bus |
| ds_issue_tag | output | TAG_W | Tag of the issued transaction |
| ds_issue_data | output | DATA_W | Payload of the issued transaction |
| ds_done | input | 1 | Slow bus has finished the issued transaction |
| ds_result | input | RES_W | Outcome of the finished transaction |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| periodic_pending | output | 1 | Periodic work queued or in flight |
| ss_overflow | output | 1 | Sticky: a start-split was dropped |

## Verification
A start-split sampled at edge k shows up on the issue port after edge k+1. A `ds_done` sampled at edge m leaves the result collectable by a complete-split sampled at edge m+2. The response to that request is visible after the edge that samples it. The vector loop drives inputs on falling edges and samples on the falling edge that follows each counted rising edge, so every check lands in exactly the cycle given above. Expiry checks wait two cycles after the third tick, which covers the one-edge purge latency. The overflow run uses a bounded poll on `ds_issue_valid`, because its queue order is the matter under test, not its timing.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_PEND = 2'b01,
        RSP_DONE = 2'b10,
        RSP_ERR  = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_ISSUE = 2'd1,
        FL_POST  = 2'd2
    } fl_state_e;

endpackage

// File: rtl/psplit_fifo.sv
module psplit_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> $stable(count));

endmodule

// File: rtl/psplit_fl_handler.sv
module psplit_fl_handler
    import psplit_pkg::*;
#(
    parameter int TAG_W         = 4,
    parameter int DATA_W        = 8,
    parameter int RES_W         = 8,
    parameter int FRAME_W       = 3,
    parameter int EXPIRE_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sq_empty,
    input  logic [TAG_W-1:0]   sq_tag,
    input  logic [DATA_W-1:0]  sq_data,
    input  logic [FRAME_W-1:0] sq_stamp,
    input  logic [FRAME_W-1:0] frame_cnt,
    output logic               sq_pop,
    input  logic               cq_full,
    output logic               cq_push,
    output logic [TAG_W-1:0]   cq_wtag,
    output logic [RES_W-1:0]   cq_wres,
    output logic               ds_issue_valid,
    output logic [TAG_W-1:0]   ds_issue_tag,
    output logic [DATA_W-1:0]  ds_issue_data,
    input  logic               ds_done,
    input  logic [RES_W-1:0]   ds_result,
    output logic               busy
);
    fl_state_e          state, nxt;
    logic [TAG_W-1:0]   cur_tag;
    logic [DATA_W-1:0]  cur_data;
    logic [RES_W-1:0]   cur_res;
    logic [FRAME_W-1:0] head_age;
    logic               head_stale;

    assign head_age   = frame_cnt - sq_stamp;
    assign head_stale = head_age > FRAME_W'(EXPIRE_FRAMES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FL_IDLE;
            cur_tag  <= '0;
            cur_data <= '0;
            cur_res  <= '0;
        end else begin
            state <= nxt;
            if (state == FL_IDLE && !sq_empty) begin
                cur_tag  <= sq_tag;
                cur_data <= sq_data;
            end
            if (state == FL_ISSUE && ds_done) cur_res <= ds_result;
        end
    end

    always_comb begin
        nxt            = state;
        sq_pop         = 1'b0;
        cq_push        = 1'b0;
        ds_issue_valid = 1'b0;
        unique case (state)
            FL_IDLE: begin
                if (!sq_empty) begin
                    sq_pop = 1'b1;
                    if (!head_stale) nxt = FL_ISSUE;
                end
            end
            FL_ISSUE: begin
                ds_issue_valid = 1'b1;
                if (ds_done) nxt = FL_POST;
            end
            FL_POST: begin
                if (!cq_full) begin
                    cq_push = 1'b1;
                    nxt     = FL_IDLE;
                end
            end
            default: nxt = FL_IDLE;
        endcase
    end

    assign ds_issue_tag  = cur_tag;
    assign ds_issue_data = cur_data;
    assign cq_wtag       = cur_tag;
    assign cq_wres       = cur_res;
    assign busy          = (state != FL_IDLE);

    // R2
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_issue_valid && !ds_done |=> ds_issue_valid && $stable(ds_issue_tag) && $stable(ds_issue_data));

endmodule

// File: rtl/psplit_cs_handler.sv
module psplit_cs_handler
    import psplit_pkg::*;
#(
    parameter int TAG_W         = 4,
    parameter int RES_W         = 8,
    parameter int FRAME_W       = 3,
    parameter int EXPIRE_FRAMES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_req,
    input  logic [TAG_W-1:0]   cs_tag,
    input  logic               cq_empty,
    input  logic [TAG_W-1:0]   cq_tag,
    input  logic [RES_W-1:0]   cq_res,
    input  logic [FRAME_W-1:0] cq_stamp,
    input  logic [FRAME_W-1:0] frame_cnt,
    output logic               cq_pop,
    output logic               cs_rsp_valid,
    output logic [1:0]         cs_rsp_kind,
    output logic [RES_W-1:0]   cs_rsp_data
);
    logic [FRAME_W-1:0] head_age;
    logic               head_stale;

    assign head_age   = frame_cnt - cq_stamp;
    assign head_stale = head_age > FRAME_W'(EXPIRE_FRAMES);
    assign cq_pop     = !cq_empty && (cs_req || head_stale);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_rsp_valid <= 1'b0;
            cs_rsp_kind  <= RSP_NONE;
            cs_rsp_data  <= '0;
        end else begin
            cs_rsp_valid <= cs_req;
            if (cs_req) begin
                if (cq_empty) begin
                    cs_rsp_kind <= RSP_PEND;
                    cs_rsp_data <= '0;
                end else if (cq_tag == cs_tag) begin
                    cs_rsp_kind <= RSP_DONE;
                    cs_rsp_data <= cq_res;
                end else begin
                    cs_rsp_kind <= RSP_ERR;
                    cs_rsp_data <= '0;
                end
            end
        end
    end

    // R4
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_req |=> cs_rsp_valid);

    // R6
    pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_req && cq_empty |=> cs_rsp_kind == RSP_PEND);

endmodule

// File: rtl/psplit_pipe.sv
module psplit_pipe
    import psplit_pkg::*;
#(
    parameter int TAG_W         = 4,
    parameter int DATA_W        = 8,
    parameter int RES_W         = 8,
    parameter int START_DEPTH   = 4,
    parameter int CPL_DEPTH     = 4,
    parameter int FRAME_W       = 3,
    parameter int EXPIRE_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_valid,
    input  logic [TAG_W-1:0]  ss_tag,
    input  logic [DATA_W-1:0] ss_data,
    input  logic              cs_req,
    input  logic [TAG_W-1:0]  cs_tag,
    output logic              cs_rsp_valid,
    output logic [1:0]        cs_rsp_kind,
    output logic [RES_W-1:0]  cs_rsp_data,
    output logic              ds_issue_valid,
    output logic [TAG_W-1:0]  ds_issue_tag,
    output logic [DATA_W-1:0] ds_issue_data,
    input  logic              ds_done,
    input  logic [RES_W-1:0]  ds_result,
    input  logic              frame_tick,
    output logic              periodic_pending,
    output logic              ss_overflow
);
    localparam int SQ_W = TAG_W + DATA_W + FRAME_W;
    localparam int CQ_W = TAG_W + RES_W + FRAME_W;

    logic [FRAME_W-1:0] frame_cnt;
    logic [SQ_W-1:0]    sq_rdata;
    logic [CQ_W-1:0]    cq_rdata;
    logic               sq_empty, sq_full, sq_pop;
    logic               cq_empty, cq_full, cq_pop, cq_push;
    logic [TAG_W-1:0]   cq_wtag;
    logic [RES_W-1:0]   cq_wres;
    logic               fl_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt   <= '0;
            ss_overflow <= 1'b0;
        end else begin
            if (frame_tick) frame_cnt <= frame_cnt + 1'b1;
            if (ss_valid && sq_full) ss_overflow <= 1'b1;
        end
    end

    psplit_fifo #(.WIDTH(SQ_W), .DEPTH(START_DEPTH)) u_start_q (
        .clk(clk), .rst_n(rst_n),
        .push(ss_valid), .pop(sq_pop),
        .wdata({ss_tag, ss_data, frame_cnt}),
        .rdata(sq_rdata), .empty(sq_empty), .full(sq_full)
    );

    psplit_fl_handler #(
        .TAG_W(TAG_W), .DATA_W(DATA_W), .RES_W(RES_W),
        .FRAME_W(FRAME_W), .EXPIRE_FRAMES(EXPIRE_FRAMES)
    ) u_fl (
        .clk(clk), .rst_n(rst_n),
        .sq_empty(sq_empty),
        .sq_tag(sq_rdata[SQ_W-1 -: TAG_W]),
        .sq_data(sq_rdata[FRAME_W +: DATA_W]),
        .sq_stamp(sq_rdata[FRAME_W-1:0]),
        .frame_cnt(frame_cnt),
        .sq_pop(sq_pop),
        .cq_full(cq_full), .cq_push(cq_push),
        .cq_wtag(cq_wtag), .cq_wres(cq_wres),
        .ds_issue_valid(ds_issue_valid),
        .ds_issue_tag(ds_issue_tag),
        .ds_issue_data(ds_issue_data),
        .ds_done(ds_done), .ds_result(ds_result),
        .busy(fl_busy)
    );

    psplit_fifo #(.WIDTH(CQ_W), .DEPTH(CPL_DEPTH)) u_cpl_q (
        .clk(clk), .rst_n(rst_n),
        .push(cq_push), .pop(cq_pop),
        .wdata({cq_wtag, cq_wres, frame_cnt}),
        .rdata(cq_rdata), .empty(cq_empty), .full(cq_full)
    );

    psplit_cs_handler #(
        .TAG_W(TAG_W), .RES_W(RES_W),
        .FRAME_W(FRAME_W), .EXPIRE_FRAMES(EXPIRE_FRAMES)
    ) u_cs (
        .clk(clk), .rst_n(rst_n),
        .cs_req(cs_req), .cs_tag(cs_tag),
        .cq_empty(cq_empty),
        .cq_tag(cq_rdata[CQ_W-1 -: TAG_W]),
        .cq_res(cq_rdata[FRAME_W +: RES_W]),
        .cq_stamp(cq_rdata[FRAME_W-1:0]),
        .frame_cnt(frame_cnt),
        .cq_pop(cq_pop),
        .cs_rsp_valid(cs_rsp_valid),
        .cs_rsp_kind(cs_rsp_kind),
        .cs_rsp_data(cs_rsp_data)
    );

    assign periodic_pending = !sq_empty || fl_busy || !cq_empty;

    // R7
    pending_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_issue_valid |-> periodic_pending);

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_valid && sq_full |=> ss_overflow);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_overflow |=> ss_overflow);

endmodule

// File: tb/psplit_pipe_test.sv
`timescale 1ns/1ps
module psplit_pipe_test;
    import psplit_pkg::*;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 8;
    localparam int RES_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ss_valid;
    logic [TAG_W-1:0]  ss_tag;
    logic [DATA_W-1:0] ss_data;
    logic              cs_req;
    logic [TAG_W-1:0]  cs_tag;
    logic              cs_rsp_valid;
    logic [1:0]        cs_rsp_kind;
    logic [RES_W-1:0]  cs_rsp_data;
    logic              ds_issue_valid;
    logic [TAG_W-1:0]  ds_issue_tag;
    logic [DATA_W-1:0] ds_issue_data;
    logic              ds_done;
    logic [RES_W-1:0]  ds_result;
    logic              frame_tick;
    logic              periodic_pending;
    logic              ss_overflow;

    always #2 clk = ~clk;

    psplit_pipe uut (
        .clk(clk), .rst_n(rst_n),
        .ss_valid(ss_valid), .ss_tag(ss_tag), .ss_data(ss_data),
        .cs_req(cs_req), .cs_tag(cs_tag),
        .cs_rsp_valid(cs_rsp_valid), .cs_rsp_kind(cs_rsp_kind), .cs_rsp_data(cs_rsp_data),
        .ds_issue_valid(ds_issue_valid), .ds_issue_tag(ds_issue_tag), .ds_issue_data(ds_issue_data),
        .ds_done(ds_done), .ds_result(ds_result),
        .frame_tick(frame_tick),
        .periodic_pending(periodic_pending),
        .ss_overflow(ss_overflow)
    );

    // tag, data, result, complete tag, expected kind
    localparam logic [25:0] VECS [0:3] = '{
        {4'h3, 8'h5A, 8'hC3, 4'h3, 2'b10},
        {4'hA, 8'h01, 8'h7E, 4'hA, 2'b10},
        {4'h5, 8'hFF, 8'h11, 4'h6, 2'b11},
        {4'h0, 8'h80, 8'h00, 4'h0, 2'b10}
    };

    int checks = 0;
    int errs   = 0;
    bit ended  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push_ss(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
        ss_valid = 1'b1; ss_tag = t; ss_data = d;
        step();
        ss_valid = 1'b0;
    endtask

    task automatic tick_frame();
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
    endtask

    task automatic complete(input logic [TAG_W-1:0] t, input logic [1:0] kind,
                            input logic [RES_W-1:0] d, input string req);
        cs_req = 1'b1; cs_tag = t;
        step();
        cs_req = 1'b0;
        chk({req, " rsp_valid"}, 32'(cs_rsp_valid), 32'd1);
        chk({req, " rsp_kind"},  32'(cs_rsp_kind),  32'(kind));
        chk({req, " rsp_data"},  32'(cs_rsp_data),  32'(d));
    endtask

    task automatic run_one(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d,
                           input logic [RES_W-1:0] r);
        for (int i = 0; i < 12 && !ds_issue_valid; i++) step();
        chk("R2 order issue_valid", 32'(ds_issue_valid), 32'd1);
        chk("R2 order issue_tag",   32'(ds_issue_tag),   32'(t));
        chk("R2 order issue_data",  32'(ds_issue_data),  32'(d));
        ds_done = 1'b1; ds_result = r;
        step();
        ds_done = 1'b0;
        step();
        complete(t, RSP_DONE, r, "R4");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ss_valid = 1'b0; ss_tag = '0; ss_data = '0;
        cs_req = 1'b0; cs_tag = '0; ds_done = 1'b0; ds_result = '0; frame_tick = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 pending",   32'(periodic_pending), 32'd0);
        chk("R1 issue",     32'(ds_issue_valid),   32'd0);
        chk("R1 overflow",  32'(ss_overflow),      32'd0);
        chk("R1 rsp_valid", 32'(cs_rsp_valid),     32'd0);

        // vector table: R2, R3, R4, R5, R7
        for (int v = 0; v < 4; v++) begin
            logic [TAG_W-1:0]  vt  = VECS[v][25:22];
            logic [DATA_W-1:0] vd  = VECS[v][21:14];
            logic [RES_W-1:0]  vr  = VECS[v][13:6];
            logic [TAG_W-1:0]  vct = VECS[v][5:2];
            logic [1:0]        vk  = VECS[v][1:0];
            push_ss(vt, vd);
            chk("R7 pending queued",  32'(periodic_pending), 32'd1);
            chk("R2 issue not yet",   32'(ds_issue_valid),   32'd0);
            step();
            chk("R2 issue_valid",     32'(ds_issue_valid),   32'd1);
            chk("R2 issue_tag",       32'(ds_issue_tag),     32'(vt));
            chk("R2 issue_data",      32'(ds_issue_data),    32'(vd));
            ds_done = 1'b1; ds_result = vr;
            step();
            ds_done = 1'b0;
            chk("R2 issue released",  32'(ds_issue_valid),   32'd0);
            chk("R7 pending posting", 32'(periodic_pending), 32'd1);
            step();
            complete(vct, vk, (vk == RSP_DONE) ? vr : '0,
                     (vk == RSP_DONE) ? "R3 R4 match" : "R5 mismatch");
            chk("R7 pending cleared", 32'(periodic_pending), 32'd0);
        end

        // R6 nothing queued
        complete(4'h9, RSP_PEND, '0, "R6 empty");

        // R8 overflow and R2 ordering: six pushes, one in flight, four queued
        for (int k = 0; k < 6; k++) push_ss(TAG_W'(k + 1), DATA_W'(8'h10 * (k + 1)));
        chk("R8 overflow set", 32'(ss_overflow), 32'd1);
        for (int k = 0; k < 5; k++) run_one(TAG_W'(k + 1), DATA_W'(8'h10 * (k + 1)), RES_W'(8'hA0 + k));
        repeat (4) step();
        chk("R8 dropped never issued", 32'(ds_issue_valid),   32'd0);
        chk("R8 pending after drain",  32'(periodic_pending), 32'd0);
        chk("R8 overflow sticky",      32'(ss_overflow),      32'd1);

        // R9 result queue entry expires after three ticks
        push_ss(4'h7, 8'h77);
        step();
        ds_done = 1'b1; ds_result = 8'h99;
        step();
        ds_done = 1'b0;
        step();
        repeat (3) tick_frame();
        step(); step();
        chk("R9 result expired pending", 32'(periodic_pending), 32'd0);
        complete(4'h7, RSP_PEND, '0, "R9 result expired");

        // R9 two ticks keep the result
        push_ss(4'h7, 8'h77);
        step();
        ds_done = 1'b1; ds_result = 8'h99;
        step();
        ds_done = 1'b0;
        step();
        repeat (2) tick_frame();
        step(); step();
        chk("R9 age two kept pending", 32'(periodic_pending), 32'd1);
        complete(4'h7, RSP_DONE, 8'h99, "R9 age two kept");

        // R9 start queue entry expires before issue
        push_ss(4'h8, 8'h88);
        step();
        chk("R9 first issued", 32'(ds_issue_tag), 32'h8);
        push_ss(4'h9, 8'h99);
        repeat (3) tick_frame();
        ds_done = 1'b1; ds_result = 8'h42;
        step();
        ds_done = 1'b0;
        step();
        complete(4'h8, RSP_DONE, 8'h42, "R9 in-flight result");
        step(); step();
        chk("R9 stale start not issued", 32'(ds_issue_valid),   32'd0);
        chk("R9 stale start pending",    32'(periodic_pending), 32'd0);

        finish_run();
    end

endmodule